// File: doc/BRIEF.md
# Three-Wire Serial Word Memory (Device Side)

This block is the responding side of a three-wire serial memory link. A host drives select (`cs`), a serial clock (`sk`) and serial data in (`di`). The block answers on `do_o`, with `do_oe` marking when that pin is driven rather than left floating. All three inputs are brought into the system clock domain through a synchronizer, and every serial bit is taken on a detected rising edge of `sk`. Behind the link sits a register array of `DATA_W`-bit words.

A transaction opens with a rising edge of `cs`. The first `di` bit sampled as 1 is the start bit. After it come a two-bit opcode and an `ADDR_W`-bit address, MSB first. The opcodes are 10 read, 01 write and 11 erase one word. Opcode 00 is a special group, selected by the two top address bits: 11 enables programming, 00 disables it, 10 fills the whole array with ones, and 01 writes one supplied word to every location.

A read sends a single 0 first and then the word. If `cs` stays high, further words follow without gaps. Programming starts a cycle timer of `PROG_CYCLES` system clocks. If the host drops `cs` and raises it again while that timer runs, `do_o` reports busy (0) and then ready (1).

The controller is one state machine with these states:

- S_IDLE: waiting for a `cs` rise.
- S_START: waiting for the start bit.
- S_OPCODE: two opcode bits.
- S_ADDR: address bits.
- S_DATA: data bits for a write or a write-to-all.
- S_READ: shifting out words.
- S_STATUS: driving ready/busy.
- S_WAIT: instruction complete, pins ignored until `cs` falls.

The transitions are:

- S_IDLE→S_START on a `cs` rise while the timer is idle.
- S_IDLE→S_STATUS on a `cs` rise while the timer runs.
- S_START→S_OPCODE on a 1 sampled on `di`.
- S_OPCODE→S_ADDR after two bits.
- S_ADDR→S_READ for a read.
- S_ADDR→S_DATA for a write or a write-to-all.
- S_ADDR→S_WAIT for every other instruction.
- S_DATA→S_WAIT after the last data bit.
- Any state→S_IDLE whenever `cs` is low.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A new instruction is accepted only after a rising edge of `cs`. Zeros sampled before the start bit are skipped. Bits sent after an instruction completes, with `cs` still high, are ignored. Dropping `cs` mid-instruction abandons it with no change to the array, and `do_oe` is 0 whenever `cs` is low.
- R2: For a read, the `sk` rising edge that takes in the last address bit drives `do_o`=0 with `do_oe`=1 (the dummy bit). Each following `sk` rising edge presents the next data bit, MSB first.
- R3: With `cs` held high after a read word, the next word (address+1) follows immediately with no dummy bit. The address wraps from the last word to word 0.
- R4: After reset, programming is disabled. Opcode 00 with top address bits 11 enables it, and opcode 00 with top address bits 00 disables it. While programming is disabled, write, erase, fill-with-ones and write-to-all leave the array untouched.
- R5: Reads return correct data whether programming is enabled or disabled.
- R6: Opcode 01 followed by `DATA_W` data bits (MSB first) stores the word at the given address.
- R7: Opcode 11 sets every bit of the addressed word to 1.
- R8: Opcode 00 with top address bits 10 sets every word to all ones. Opcode 00 with top address bits 01 followed by a data word stores that word in every location.
- R9: A programming cycle of `PROG_CYCLES` clocks starts after the last data bit (write, write-to-all) or the last address bit (erase, fill). If `cs` rises while the cycle runs, `do_oe`=1, `do_o` shows 0, and `do_o` switches to 1 once the cycle ends.
- R10: If `cs` rises only after the cycle has ended, no status is driven (`do_oe`=0).
- R11: When `TOP_ADDR_DC`=1, the top address bit is clocked in but ignored, so addresses differing only in that bit reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select from host, active high |
| sk | input | 1 | Serial bit clock from host |
| di | input | 1 | Serial data from host |
| do_o | output | 1 | Serial data / ready-busy to host |
| do_oe | output | 1 | Drive enable for `do_o` (0 = high impedance) |

## Verification
The bench builds the block with `ADDR_W`=6, `TOP_ADDR_DC`=1, `DATA_W`=16 and `PROG_CYCLES`=60. That gives a 32-word array, so sequential reads can be driven across the last-to-first wrap, and the ignored top address bit can be shown aliasing onto a word in the low half. The 60-clock cycle is short enough that both a `cs` re-raise inside the busy window and one after it can be placed by a fixed delay.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_OPCODE,
        S_ADDR,
        S_DATA,
        S_READ,
        S_STATUS,
        S_WAIT
    } mw_state_t;

    typedef enum logic [1:0] {
        OP_SPEC  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_t;

    // selector in the two top address bits under OP_SPEC
    localparam logic [1:0] SUB_PROT  = 2'b00;
    localparam logic [1:0] SUB_FILLW = 2'b01;
    localparam logic [1:0] SUB_FILL1 = 2'b10;
    localparam logic [1:0] SUB_UNPROT = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
`timescale 1ns/1ps
module mw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pins_i,   // {di, sk, cs}
    output logic [2:0] lvl_o,
    output logic [1:0] rise_o    // {sk, cs}
);

    logic [2:0] chain_q [STAGES];
    logic [1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= pins_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[g] <= '0;
            end else begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= chain_q[STAGES-1][1:0];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1][1:0] & ~prev_q;

endmodule

// File: rtl/mw_word_array.sv
`timescale 1ns/1ps
module mw_word_array #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we_all || (we_one && (waddr == IDX_W'(i)))) begin
                mem_q[i] <= wdata;
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mw_prog_timer.sv
`timescale 1ns/1ps
module mw_prog_timer #(
    parameter int PROG_CYCLES = 500,
    localparam int TW = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= TW'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R9

endmodule

// File: rtl/mw_eeprom_slave.sv
`timescale 1ns/1ps
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int TOP_ADDR_DC = 1,
    parameter int PROG_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);

    localparam int EFF_W = ADDR_W - TOP_ADDR_DC;
    localparam int MAXB  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    // ---------------- pin synchronizer ----------------
    logic [2:0] lvl;
    logic [1:0] rise;
    logic       cs_l, di_l, cs_rise, sk_rise;

    mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins_i({di, sk, cs}),
        .lvl_o (lvl),
        .rise_o(rise)
    );

    assign cs_l    = lvl[0];
    assign di_l    = lvl[2];
    assign cs_rise = rise[0];
    assign sk_rise = rise[1];

    // ---------------- registers ----------------
    mw_state_t          state_q, state_d;
    mw_op_t             op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [DATA_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               wen_q;
    logic               do_q, oe_q;

    // ---------------- datapath helpers ----------------
    logic [ADDR_W-1:0]  full_addr;
    logic [DATA_W-1:0]  full_data;
    logic [1:0]         sub_sel;
    logic               last_bit;
    logic [EFF_W-1:0]   ptr_next;

    assign full_addr = {addr_q[ADDR_W-2:0], di_l};
    assign full_data = {data_q[DATA_W-2:0], di_l};
    assign sub_sel   = full_addr[ADDR_W-1 -: 2];
    assign last_bit  = sk_rise && (cnt_q == CNT_W'(1));
    assign ptr_next  = addr_q[EFF_W-1:0] + 1'b1;

    // ---------------- array and timer ----------------
    logic               busy;
    logic               tmr_start;
    logic               mem_we_one, mem_we_all;
    logic [EFF_W-1:0]   mem_waddr, mem_raddr;
    logic [DATA_W-1:0]  mem_wdata, mem_rdata;

    mw_word_array #(.DATA_W(DATA_W), .IDX_W(EFF_W)) u_array (
        .clk   (clk),
        .we_one(mem_we_one),
        .we_all(mem_we_all),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .busy (busy)
    );

    assign mem_raddr = (state_q == S_READ) ? ptr_next : full_addr[EFF_W-1:0];

    // programming strobes, issued only on the closing bit of an instruction
    always_comb begin
        mem_we_one = 1'b0;
        mem_we_all = 1'b0;
        mem_wdata  = '1;
        mem_waddr  = full_addr[EFF_W-1:0];
        tmr_start  = 1'b0;
        if (cs_l && last_bit && wen_q) begin
            if (state_q == S_ADDR) begin
                if (op_q == OP_ERASE) begin
                    mem_we_one = 1'b1;
                    tmr_start  = 1'b1;
                end else if (op_q == OP_SPEC && sub_sel == SUB_FILL1) begin
                    mem_we_all = 1'b1;
                    tmr_start  = 1'b1;
                end
            end else if (state_q == S_DATA) begin
                mem_wdata  = full_data;
                mem_waddr  = addr_q[EFF_W-1:0];
                mem_we_one = (op_q == OP_WRITE);
                mem_we_all = (op_q != OP_WRITE);
                tmr_start  = 1'b1;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (!cs_l) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:   if (cs_rise) state_d = busy ? S_STATUS : S_START;
                S_START:  if (sk_rise && di_l) state_d = S_OPCODE;
                S_OPCODE: if (last_bit) state_d = S_ADDR;
                S_ADDR: begin
                    if (last_bit) begin
                        unique case (op_q)
                            OP_READ:  state_d = S_READ;
                            OP_WRITE: state_d = S_DATA;
                            OP_ERASE: state_d = S_WAIT;
                            OP_SPEC:  state_d = (sub_sel == SUB_FILLW) ? S_DATA : S_WAIT;
                            default:  state_d = S_WAIT;
                        endcase
                    end
                end
                S_DATA:   if (last_bit) state_d = S_WAIT;
                S_READ:   state_d = S_READ;
                S_STATUS: state_d = S_STATUS;
                S_WAIT:   state_d = S_WAIT;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_SPEC;
            addr_q  <= '0;
            data_q  <= '0;
            shreg_q <= '0;
            cnt_q   <= '0;
            wen_q   <= 1'b0;
            do_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (!cs_l) begin
            oe_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    oe_q <= 1'b0;
                end
                S_START: begin
                    if (sk_rise && di_l) cnt_q <= CNT_W'(2);
                end
                S_OPCODE: begin
                    if (sk_rise) begin
                        op_q  <= mw_op_t'({op_q[0], di_l});
                        cnt_q <= last_bit ? CNT_W'(ADDR_W) : cnt_q - 1'b1;
                    end
                end
                S_ADDR: begin
                    if (sk_rise) begin
                        addr_q <= full_addr;
                        if (last_bit) begin
                            cnt_q <= CNT_W'(DATA_W);
                            if (op_q == OP_READ) begin
                                shreg_q <= mem_rdata;
                                do_q    <= 1'b0;
                                oe_q    <= 1'b1;
                            end else if (op_q == OP_SPEC) begin
                                if (sub_sel == SUB_UNPROT)    wen_q <= 1'b1;
                                else if (sub_sel == SUB_PROT) wen_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (sk_rise) begin
                        data_q <= full_data;
                        cnt_q  <= cnt_q - 1'b1;
                    end
                end
                S_READ: begin
                    if (sk_rise) begin
                        do_q <= shreg_q[DATA_W-1];
                        if (last_bit) begin
                            shreg_q <= mem_rdata;
                            addr_q  <= addr_q + 1'b1;
                            cnt_q   <= CNT_W'(DATA_W);
                        end else begin
                            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                            cnt_q   <= cnt_q - 1'b1;
                        end
                    end
                end
                S_STATUS: begin
                    oe_q <= 1'b1;
                    do_q <= ~busy;
                end
                S_WAIT: begin
                    oe_q <= 1'b0;
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign do_o  = do_q;
    assign do_oe = oe_q;

    // ---------------- assertions ----------------
    AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_l |=> !do_oe); // R1
    AST_DUMMY_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_READ && $past(state_q) == S_ADDR) |-> (do_oe && !do_o)); // R2
    AST_WEN_ONLY_BY_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen_q) |-> ($past(state_q) == S_ADDR && $past(op_q) == OP_SPEC)); // R4
    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_one || mem_we_all) |-> wen_q); // R4
    AST_STATUS_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STATUS && $past(state_q) == S_STATUS) |-> (do_oe && (do_o == !$past(busy)))); // R9

endmodule

// File: tb/mw_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module mw_eeprom_slave_tb_top;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DC    = 1;
    localparam int PC    = 60;
    localparam int EW    = AW - DC;
    localparam int DEPTH = 1 << EW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;

    always #2.5 clk = ~clk;

    mw_eeprom_slave #(
        .ADDR_W(AW), .DATA_W(DW), .TOP_ADDR_DC(DC), .PROG_CYCLES(PC), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DEPTH];
    bit wen_m = 1'b0;
    logic s_do, s_oe;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        di = b;
        tick(2);
        sk = 1'b1;
        tick(4);
        s_do = do_o;
        s_oe = do_oe;
        sk = 1'b0;
        tick(2);
    endtask

    task automatic cs_up();
        cs = 1'b1;
        tick(4);
    endtask

    task automatic cs_down();
        cs = 1'b0;
        tick(4);
    endtask

    task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input int lead0);
        for (int i = 0; i < lead0; i++) pulse(1'b0);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic send_data(input logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) pulse(d[i]);
    endtask

    function automatic int eff(input logic [AW-1:0] a);
        return int'(a[EW-1:0]);
    endfunction

    function automatic logic [AW-1:0] spec_addr(input logic [1:0] sub);
        return {sub, {(AW-2){1'b0}}};
    endfunction

    task automatic read_chk(input logic [AW-1:0] a, input int nw, input int lead0, input string req);
        logic [DW-1:0] w;
        cs_up();
        send(2'b10, a, lead0);
        chk_eq({req, " R2 dummy"}, {30'd0, s_oe, s_do}, 32'h2);
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int b = 0; b < DW; b++) begin
                pulse(1'b0);
                w = {w[DW-2:0], s_do};
            end
            chk_eq(req, w, model[(eff(a) + k) % DEPTH]);
        end
        cs_down();
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_up(); send(2'b01, a, 0); send_data(d); cs_down();
        if (wen_m) model[eff(a)] = d;
        tick(PC + 20);
    endtask

    task automatic do_erase(input logic [AW-1:0] a);
        cs_up(); send(2'b11, a, 0); cs_down();
        if (wen_m) model[eff(a)] = '1;
        tick(PC + 20);
    endtask

    task automatic do_fill1();
        cs_up(); send(2'b00, spec_addr(2'b10), 0); cs_down();
        if (wen_m) for (int i = 0; i < DEPTH; i++) model[i] = '1;
        tick(PC + 20);
    endtask

    task automatic do_fillw(input logic [DW-1:0] d);
        cs_up(); send(2'b00, spec_addr(2'b01), 0); send_data(d); cs_down();
        if (wen_m) for (int i = 0; i < DEPTH; i++) model[i] = d;
        tick(PC + 20);
    endtask

    task automatic set_wen(input bit en);
        cs_up(); send(2'b00, spec_addr(en ? 2'b11 : 2'b00), 0); cs_down();
        wen_m = en;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk_eq("R1 reset oe", {31'd0, do_oe}, 32'd0);

        // programming disabled at reset: fill must be ignored, array unknown -> establish via enable
        set_wen(1'b1);
        do_fill1();
        read_chk(6'd0, 2, 0, "R8 fill ones");
        set_wen(1'b0);
        do_write(6'd3, 16'h1234);
        do_erase(6'd4);
        read_chk(6'd3, 1, 0, "R4 R5 write ignored when disabled");
        do_fillw(16'h0F0F);
        read_chk(6'd8, 1, 0, "R4 write-all ignored when disabled");

        // enabled writes
        set_wen(1'b1);
        do_write(6'd5, 16'hA5C3);
        read_chk(6'd5, 1, 0, "R6 write");
        do_write(6'd6, 16'h8001);
        do_write(6'd7, 16'h7FFE);
        read_chk(6'd5, 3, 0, "R3 sequential");
        do_write(6'd31, 16'h1357);
        do_write(6'd0, 16'h2468);
        read_chk(6'd31, 2, 0, "R3 wrap");
        do_write(6'h22, 16'hCAFE);
        read_chk(6'h02, 1, 0, "R11 top bit ignored");
        do_erase(6'd5);
        read_chk(6'd5, 1, 0, "R7 erase");
        do_fillw(16'h3C3C);
        read_chk(6'd0, 4, 0, "R8 write-all");
        do_fill1();
        read_chk(6'd20, 2, 0, "R8 fill ones");

        // R1: leading zeros before start bit
        do_write(6'd9, 16'h5AA5);
        read_chk(6'd9, 1, 3, "R1 leading zeros");
        // R1: aborted write
        cs_up(); send(2'b01, 6'd9, 0);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        cs_down();
        chk_eq("R1 oe after cs low", {31'd0, do_oe}, 32'd0);
        tick(PC + 20);
        read_chk(6'd9, 1, 0, "R1 abort leaves word");
        // R1: bits after a completed instruction with cs still high
        cs_up(); send(2'b11, 6'd10, 0);
        send(2'b01, 6'd10, 0); send_data(16'h0000);
        cs_down();
        model[10] = '1;
        tick(PC + 20);
        read_chk(6'd10, 1, 0, "R1 no restart without cs edge");

        // R9: busy then ready
        cs_up(); send(2'b01, 6'd11, 0); send_data(16'hBEEF);
        cs = 1'b0; tick(4);
        cs = 1'b1; tick(6);
        chk_eq("R9 busy", {30'd0, do_oe, do_o}, 32'h2);
        tick(PC + 20);
        chk_eq("R9 ready", {30'd0, do_oe, do_o}, 32'h3);
        cs_down();
        chk_eq("R1 status released", {31'd0, do_oe}, 32'd0);
        model[11] = 16'hBEEF;
        read_chk(6'd11, 1, 0, "R9 data landed");

        // R10: cs raised after the cycle ended
        cs_up(); send(2'b11, 6'd12, 0); cs_down();
        model[12] = '1;
        tick(PC + 20);
        cs = 1'b1; tick(6);
        chk_eq("R10 no status", {31'd0, do_oe}, 32'd0);
        cs_down();

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            r  = $urandom;
            ra = AW'($urandom);
            rd = DW'($urandom);
            case (r % 6)
                0: set_wen(!wen_m);
                1, 2, 3: do_write(ra, rd);
                default: read_chk(ra, 1 + int'((r >> 4) % 3), 0, "R5 R6 random");
            endcase
        end
        read_chk(6'd0, DEPTH, 0, "R3 R6 full sweep");

        finish_run();
    end

endmodule